// File: doc/BRIEF.md
# Chainable Cache Event Counter Bank

This block is a bank of 32-bit event counters meant to sit beside a cache slice. It receives a wide vector of one-cycle event pulses. Each counter has an 8-bit selector, and the selector value indexes that vector directly. Software controls the bank through a plain register port made of valid, write, address and data signals, with read data returned one cycle later. Through this port software can pick an event for each counter, load or read a counter's value, set or clear the per-counter count enables and interrupt enables, arm each counter's start, and turn the whole bank on or off with one global enable bit.

Two neighbouring counters, an even one and the odd one above it, can be joined into a single 64-bit counter. In that mode the odd counter stops following its own event and advances only on the carry out of the even counter. Each counter can also raise a status bit whenever its bit 31 changes, in either direction. Because of this, software can leave a 32-bit counter running from zero and never reload it, and still catch every half-range step. The interrupt line is a registered OR of the status bits whose interrupt enable is set.

Top module: `evc_bank`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is low and `bus_rvalid` is low.
- R2: In a clock cycle, a counter that is not in the odd half of a chained pair advances by exactly one when all of these are true: the global enable is 1, the counter's count enable is 1, the counter is armed, its selector is nonzero, and `evt_in[selector]` is high. In every other cycle it keeps its value. Selector 0 never counts.
- R3: A write to a counter's value register (address 0x2n, where n is the counter number) loads the written data. This write wins over an increment that happens in the same cycle.
- R4: The chain register is at address 0x06. Bit k of this register can be stored only when k is even and counter k+1 exists; all other bits always read 0. When bit k is set, counter k+1 ignores its own event and advances by one only in a cycle where counter k goes from all ones to zero.
- R5: The flip-interrupt enable register is at address 0x07. When bit n of this register is set and an increment changes bit 31 of counter n (from 0 to 1 or from 1 to 0), bit n of the status register is set.
- R6: The status register is at address 0x05. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged. If a bit is cleared and set in the same cycle, it ends up set.
- R7: The count enable can be set at address 0x01 and cleared at address 0x02. The interrupt enable can be set at address 0x03 and cleared at address 0x04. For each of these registers, bit n of the written data acts on counter n, and 0 bits in the data change nothing. Reading either address of a pair returns the current mask.
- R8: `irq` equals the OR over all n of (status bit n AND interrupt enable bit n), registered, so it follows the state one cycle later.
- R9: The global enable is bit 0 of address 0x00. Writing 0 to it stops all counting, leaves the count enables unchanged, and disarms every counter. A counter is armed by writing 1 to bit 0 of address 0x3n, and that address reads back the armed state. After the global enable is set again, a counter stays idle until it has been armed again.
- R10: A read (`bus_valid` high and `bus_write` low) returns data on `bus_rdata`, with `bus_rvalid` high, on the cycle after the request. The address is split as group in bits 7:4 and index in bits 3:0. The selector of counter n is at 0x1n. Any address not defined in these requirements reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A register access is requested this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Register address: group in bits 7:4, index in bits 3:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High on the cycle after a read request |
| evt_in | input | 256 | Event pulse vector, indexed by the selector value |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that at most one register access happens per cycle. They also assume that the bus inputs are driven to known values during reset, because some checks look at the cycle just after reset through `$past`. The bench meets both assumptions by driving exactly one operation per cycle from a single task, starting with idle zeros. The random stimulus loads counters just below 0x80000000 and 0xFFFFFFFF so that flips and carries happen often. It uses dense event vectors and small selector codes, and it usually keeps the global enable and the arm bits set, so that counting continues between the occasional disables.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int ADDR_W = 8;
  localparam int FLD_W  = 4;

  // address groups (bits 7:4)
  localparam logic [FLD_W-1:0] GRP_CTL = 4'h0;
  localparam logic [FLD_W-1:0] GRP_SEL = 4'h1;
  localparam logic [FLD_W-1:0] GRP_VAL = 4'h2;
  localparam logic [FLD_W-1:0] GRP_ARM = 4'h3;

  // control group indices (bits 3:0)
  localparam logic [FLD_W-1:0] REG_GEN     = 4'h0;
  localparam logic [FLD_W-1:0] REG_CEN_SET = 4'h1;
  localparam logic [FLD_W-1:0] REG_CEN_CLR = 4'h2;
  localparam logic [FLD_W-1:0] REG_IE_SET  = 4'h3;
  localparam logic [FLD_W-1:0] REG_IE_CLR  = 4'h4;
  localparam logic [FLD_W-1:0] REG_STATUS  = 4'h5;
  localparam logic [FLD_W-1:0] REG_CHAIN   = 4'h6;
  localparam logic [FLD_W-1:0] REG_FLIP_IE = 4'h7;
endpackage

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          own_hit,
  input  logic          chain_mode,
  input  logic          carry_in,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt_q,
  output logic          carry_out,
  output logic          msb_flip
);
  logic step;

  // odd half of a chained pair follows the carry, never its own event
  assign step      = chain_mode ? carry_in : own_hit;
  assign carry_out = step & ~wr_en & (&cnt_q);
  assign msb_flip  = step & ~wr_en & (&cnt_q[CW-2:0]);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  p_write_wins_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt_q == $past(wr_data)));

  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int NC = 8,
  parameter int SW = 8,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic [FLD_W-1:0]     grp,
  input  logic [FLD_W-1:0]     idx,
  input  logic [DW-1:0]        wdata,
  input  logic [NC-1:0]        flip,
  output logic                 gen_q,
  output logic [NC-1:0]        cen_q,
  output logic [NC-1:0]        ie_q,
  output logic [NC-1:0]        fie_q,
  output logic [NC-1:0]        ovf_q,
  output logic [NC-1:0]        chain_q,
  output logic [NC-1:0]        armed_q,
  output logic [NC-1:0][SW-1:0] sel_q,
  output logic                 irq_q
);
  function automatic logic [NC-1:0] pair_heads();
    logic [NC-1:0] m;
    m = '0;
    for (int k = 0; k < NC; k++) m[k] = (k % 2 == 0) && (k + 1 < NC);
    return m;
  endfunction

  localparam logic [NC-1:0] HEAD_MASK = pair_heads();

  logic          ctl_wr;
  logic          gen_off_wr;
  logic [NC-1:0] wmask;
  logic [NC-1:0] ovf_clr;
  logic [NC-1:0] ovf_set;
  logic          unused_ctrl;

  assign ctl_wr      = wr_stb && (grp == GRP_CTL);
  assign wmask       = wdata[NC-1:0];
  assign gen_off_wr  = ctl_wr && (idx == REG_GEN) && !wdata[0];
  assign ovf_clr     = (ctl_wr && (idx == REG_STATUS)) ? wmask : '0;
  assign ovf_set     = flip & fie_q;
  assign unused_ctrl = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q   <= 1'b0;
      cen_q   <= '0;
      ie_q    <= '0;
      fie_q   <= '0;
      ovf_q   <= '0;
      chain_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
      irq_q <= |(ovf_q & ie_q);
      if (ctl_wr) begin
        case (idx)
          REG_GEN:     gen_q   <= wdata[0];
          REG_CEN_SET: cen_q   <= cen_q | wmask;
          REG_CEN_CLR: cen_q   <= cen_q & ~wmask;
          REG_IE_SET:  ie_q    <= ie_q | wmask;
          REG_IE_CLR:  ie_q    <= ie_q & ~wmask;
          REG_CHAIN:   chain_q <= wmask & HEAD_MASK;
          REG_FLIP_IE: fie_q   <= wmask;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= '0;
      sel_q   <= '0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (gen_off_wr)
          armed_q[i] <= 1'b0;
        else if (wr_stb && grp == GRP_ARM && idx == FLD_W'(i))
          armed_q[i] <= wdata[0];
        if (wr_stb && grp == GRP_SEL && idx == FLD_W'(i))
          sel_q[i] <= wdata[SW-1:0];
      end
    end
  end

  p_status_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_q & $past(ovf_q & ~ovf_clr)) == $past(ovf_q & ~ovf_clr)));

  p_flip_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (|ovf_set) |=> ((ovf_q & $past(ovf_set)) == $past(ovf_set)));

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == $past(|(ovf_q & ie_q))));

  p_disarm_r9: assert property (@(posedge clk) disable iff (rst)
    gen_off_wr |=> (armed_q == '0 && !gen_q));

  p_cen_set_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && idx == REG_CEN_SET) |=> ((cen_q & $past(wmask)) == $past(wmask)));
endmodule

// File: rtl/evc_bank.sv
module evc_bank
  import evc_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 32,
  parameter int SEL_W   = 8,
  localparam int EVT_W  = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTR_W-1:0]  bus_wdata,
  output logic [CTR_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [EVT_W-1:0]  evt_in,
  output logic              irq
);
  logic [FLD_W-1:0]            grp;
  logic [FLD_W-1:0]            idx;
  logic                        wr_stb;
  logic                        rd_stb;
  logic                        gen_q;
  logic [NUM_CTR-1:0]          cen_q, ie_q, fie_q, ovf_q, chain_q, armed_q;
  logic [NUM_CTR-1:0][SEL_W-1:0] sel_q;
  logic [NUM_CTR-1:0]          carry, flip;
  logic [CTR_W-1:0]            cnt [NUM_CTR];
  logic [CTR_W-1:0]            rd_mux;
  logic                        unused_top;

  assign grp        = bus_addr[ADDR_W-1:FLD_W];
  assign idx        = bus_addr[FLD_W-1:0];
  assign wr_stb     = bus_valid && bus_write;
  assign rd_stb     = bus_valid && !bus_write;
  assign unused_top = ^{carry, chain_q};

  evc_ctrl #(.NC(NUM_CTR), .SW(SEL_W), .DW(CTR_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .grp     (grp),
    .idx     (idx),
    .wdata   (bus_wdata),
    .flip    (flip),
    .gen_q   (gen_q),
    .cen_q   (cen_q),
    .ie_q    (ie_q),
    .fie_q   (fie_q),
    .ovf_q   (ovf_q),
    .chain_q (chain_q),
    .armed_q (armed_q),
    .sel_q   (sel_q),
    .irq_q   (irq)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic own_hit, chain_mode, carry_in, val_wr;

    assign own_hit = gen_q & cen_q[i] & armed_q[i] & (sel_q[i] != '0) & evt_in[sel_q[i]];
    assign val_wr  = wr_stb && (grp == GRP_VAL) && (idx == FLD_W'(i));

    if (i % 2 == 1) begin : g_odd
      assign chain_mode = chain_q[i-1];
      assign carry_in   = carry[i-1];

      p_odd_follows_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (chain_q[i-1] && !carry[i-1] && !val_wr) |=> $stable(cnt[i]));
    end else begin : g_even
      assign chain_mode = 1'b0;
      assign carry_in   = 1'b0;
    end

    evc_counter #(.CW(CTR_W)) u_ctr (
      .clk        (clk),
      .rst        (rst),
      .own_hit    (own_hit),
      .chain_mode (chain_mode),
      .carry_in   (carry_in),
      .wr_en      (val_wr),
      .wr_data    (bus_wdata),
      .cnt_q      (cnt[i]),
      .carry_out  (carry[i]),
      .msb_flip   (flip[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (grp)
      GRP_CTL: begin
        case (idx)
          REG_GEN:                 rd_mux = CTR_W'(gen_q);
          REG_CEN_SET, REG_CEN_CLR: rd_mux = CTR_W'(cen_q);
          REG_IE_SET, REG_IE_CLR:   rd_mux = CTR_W'(ie_q);
          REG_STATUS:              rd_mux = CTR_W'(ovf_q);
          REG_CHAIN:               rd_mux = CTR_W'(chain_q);
          REG_FLIP_IE:             rd_mux = CTR_W'(fie_q);
          default:                 rd_mux = '0;
        endcase
      end
      GRP_SEL: for (int i = 0; i < NUM_CTR; i++) if (idx == FLD_W'(i)) rd_mux = CTR_W'(sel_q[i]);
      GRP_VAL: for (int i = 0; i < NUM_CTR; i++) if (idx == FLD_W'(i)) rd_mux = cnt[i];
      GRP_ARM: for (int i = 0; i < NUM_CTR; i++) if (idx == FLD_W'(i)) rd_mux = CTR_W'(armed_q[i]);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_stb;
      if (rd_stb) bus_rdata <= rd_mux;
    end
  end

  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bus_rvalid == $past(rd_stb)));
endmodule

// File: tb/tb_evc_bank.sv
module tb_evc_bank;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_valid = 1'b0;
  logic         bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [255:0] evt_in = '0;
  logic         irq;

  always #5 clk = ~clk;

  evc_bank dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_in(evt_in), .irq(irq)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state
  bit         m_gen;
  bit [7:0]   m_cen, m_ie, m_fie, m_ovf, m_chain, m_armed;
  bit [7:0]   m_sel [8];
  bit [31:0]  m_cnt [8];
  bit [255:0] cur_ev = '1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit [3:0] g, i;
    g = a[7:4]; i = a[3:0];
    if (g == 0) begin
      case (i)
        0: return {31'b0, m_gen};
        1, 2: return {24'b0, m_cen};
        3, 4: return {24'b0, m_ie};
        5: return {24'b0, m_ovf};
        6: return {24'b0, m_chain};
        7: return {24'b0, m_fie};
        default: return 0;
      endcase
    end
    if (i >= 8) return 0;
    case (g)
      1: return {24'b0, m_sel[i]};
      2: return m_cnt[i];
      3: return {31'b0, m_armed[i]};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(bit [7:0] a);
    if (a[7:4] == 0) begin
      case (a[3:0])
        0: return "R9 gen";
        1, 2, 3, 4: return "R7 enables";
        5: return "R6 status";
        6: return "R4 chain";
        7: return "R5 flip enable";
        default: return "R10 unmapped";
      endcase
    end
    if (a[3:0] >= 8) return "R10 unmapped";
    case (a[7:4])
      1: return "R10 selector";
      2: return "R2 value";
      3: return "R9 armed";
      default: return "R10 unmapped";
    endcase
  endfunction

  task automatic m_step(bit v, bit w, bit [7:0] a, bit [31:0] d, bit [255:0] ev);
    bit [31:0] old [8];
    bit [7:0]  cy, fl, clr;
    bit        stp, wr;
    old = m_cnt;
    cy = '0; fl = '0;
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 1 && m_chain[i-1]) stp = cy[i-1];
      else stp = m_gen && m_cen[i] && m_armed[i] && m_sel[i] != 0 && ev[m_sel[i]];
      wr = v && w && a[7:4] == 2 && a[3:0] == 4'(i);
      cy[i] = stp && !wr && old[i] == 32'hFFFF_FFFF;
      fl[i] = stp && !wr && old[i][30:0] == 31'h7FFF_FFFF;
      if (wr) m_cnt[i] = d;
      else if (stp) m_cnt[i] = old[i] + 1;
    end
    clr = (v && w && a == 8'h05) ? d[7:0] : 8'h00;
    m_ovf = (m_ovf & ~clr) | (fl & m_fie);
    if (v && w) begin
      if (a[7:4] == 0) begin
        case (a[3:0])
          0: begin m_gen = d[0]; if (!d[0]) m_armed = '0; end
          1: m_cen = m_cen | d[7:0];
          2: m_cen = m_cen & ~d[7:0];
          3: m_ie = m_ie | d[7:0];
          4: m_ie = m_ie & ~d[7:0];
          6: m_chain = d[7:0] & 8'h55;
          7: m_fie = d[7:0];
          default: ;
        endcase
      end else if (a[3:0] < 8) begin
        if (a[7:4] == 1) m_sel[a[3:0]] = d[7:0];
        if (a[7:4] == 3) m_armed[a[3:0]] = d[0];
      end
    end
  endtask

  task automatic op(bit v, bit w, bit [7:0] a, bit [31:0] d, bit [255:0] ev, string tg);
    bit [31:0] exp_rd;
    bit        exp_irq, rd;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; evt_in = ev;
    rd      = v && !w;
    exp_rd  = m_read(a);
    exp_irq = |(m_ovf & m_ie);
    m_step(v, w, a, d, ev);
    @(posedge clk);
    @(negedge clk);
    chk("R8 irq", {31'b0, irq}, {31'b0, exp_irq});
    if (rd) begin
      chk(tg == "" ? tag_of(a) : tg, bus_rdata, exp_rd);
      chk("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
    end
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    op(1, 1, a, d, cur_ev, "");
  endtask

  task automatic rd(bit [7:0] a, string tg);
    op(1, 0, a, 0, cur_ev, tg);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) op(0, 0, 0, 0, cur_ev, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 rvalid", {31'b0, bus_rvalid}, 32'd0);
    for (int i = 0; i < 8; i++) rd(8'(i), "R1");
    rd(8'h10, "R1"); rd(8'h20, "R1"); rd(8'h30, "R1");

    // R4: chained pair 0/1, odd bit of chain register dropped
    cur_ev = '1;
    wr(8'h00, 1); wr(8'h01, 32'h3); wr(8'h06, 32'h3);
    rd(8'h06, "R4");
    wr(8'h10, 5); wr(8'h11, 6);
    wr(8'h20, 32'hFFFF_FFFE); wr(8'h21, 7);
    wr(8'h30, 1); wr(8'h31, 1);
    idle(4);
    rd(8'h21, "R4"); rd(8'h20, "R4");
    idle(3);
    rd(8'h21, "R4");

    // R3: write beats increment
    wr(8'h20, 32'h0000_1234);
    rd(8'h20, "R3");
    rd(8'h20, "R3");

    // R9: global disable keeps enables, disarms, needs re-arm
    wr(8'h00, 0);
    rd(8'h01, "R9"); rd(8'h30, "R9");
    wr(8'h00, 1); idle(3);
    rd(8'h20, "R9"); rd(8'h20, "R9");
    wr(8'h30, 1); idle(2);
    rd(8'h20, "R2");

    // R5/R6: bit 31 flips both ways set status, W1C
    wr(8'h07, 32'h4); wr(8'h03, 32'h4); wr(8'h12, 1);
    wr(8'h22, 32'h7FFF_FFFD); wr(8'h01, 32'h4); wr(8'h32, 1);
    idle(4);
    rd(8'h05, "R5");
    wr(8'h05, 32'h4);
    rd(8'h05, "R6");
    wr(8'h22, 32'hFFFF_FFFE); idle(4);
    rd(8'h05, "R5");
    wr(8'h05, 0);
    rd(8'h05, "R6");

    // R7: zero bits ignored, one bits clear
    wr(8'h02, 0); rd(8'h01, "R7");
    wr(8'h02, 1); rd(8'h02, "R7");
    wr(8'h04, 32'h4); rd(8'h03, "R7");
    rd(8'h4C, "R10"); rd(8'h0B, "R10");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit [7:0]   a;
      bit [31:0]  d;
      bit [255:0] ev;
      int         r;
      for (int k = 0; k < 8; k++) ev[k*32 +: 32] = $urandom() | $urandom();
      r = int'($urandom() % 100);
      a = {4'($urandom() % 5), 4'($urandom() % 10)};
      if (r < 40) begin
        op(0, 0, 0, 0, ev, "");
      end else if (r < 70) begin
        op(1, 0, a, 0, ev, "");
      end else begin
        d = $urandom();
        case (a[7:4])
          0: if (a[3:0] == 0) d = ($urandom() % 8 == 0) ? 0 : 1;
          1: d = ($urandom() % 4 == 0) ? 0 : 32'($urandom() % 16);
          2: case ($urandom() % 4)
               0: d = 32'h7FFF_FFFF - ($urandom() % 4);
               1: d = 32'hFFFF_FFFF - ($urandom() % 4);
               2: d = 0;
               default: ;
             endcase
          3: d = ($urandom() % 6 == 0) ? 0 : 1;
          default: ;
        endcase
        op(1, 1, a, d, ev, "");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule